// File: doc/BRIEF.md
# Power-On Strap Capture and Pin Turnaround Sequencer

This block owns six shared pads. Each pad carries a configuration level set by a board resistor while the system comes up, and carries a clock once start-up is over. From reset the block keeps every pad driver off, so the pads float and the straps set their levels. It then counts a fixed number of reference-clock cycles, which is about two milliseconds at 14.318 MHz.

When the count runs out, the block takes one sample of all six pad levels and holds them in a configuration register. In the same clock edge it turns on every pad driver. Five of the held bits form the frequency-select code for the downstream clock logic. The sixth bit chooses the rate of the serial-I/O clock. A qualifying flag tells consumers when the held values are usable. A reset at any time puts the block back into its floating, counting state.

Top module: `strap_capture_top`

## Requirements
- R1: While reset is low, and right after it, `padOe` is 0, `strapValid` is 0, `fsCode` is 0 and `sioRate24` is 0.
- R2: After reset is released, `padOe` stays 0 for exactly `TERM_COUNT` rising edges of `clk` and becomes all ones on edge number `TERM_COUNT`. From then on it stays all ones until the next reset.
- R3: `fsCode[4:0]` equals `padIn[4:0]` as it was in the clock cycle just before `padOe` rose. Bit i of `fsCode` comes from pad i.
- R4: `sioRate24` equals `padIn[5]` as it was in that same cycle. A 1 means the 24 MHz rate and a 0 means the 48 MHz rate.
- R5: `strapValid` rises in the same cycle as `padOe`. All six enables change together.
- R6: After `strapValid` is 1, changes on `padIn` do not affect `fsCode` or `sioRate24` until the next reset.
- R7: While a pad's enable is 0, its `padOut` bit is 0. While the enable is 1, `padOut` follows `clkSrc` on that pad.
- R8: Asserting reset at any point clears `padOe` and `strapValid`. After release, the full `TERM_COUNT` wait starts again.
- R9: Pad levels present before the final waiting cycle do not affect the captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that drives the wait timer |
| rstN | input | 1 | Asynchronous active-low reset |
| padIn | input | 6 | Level read back from each shared pad |
| clkSrc | input | 6 | Clock to drive onto each pad once drivers are on |
| padOut | output | 6 | Data value for each pad driver |
| padOe | output | 6 | Driver enable for each pad; 0 means high impedance |
| fsCode | output | 5 | Captured frequency-select code |
| sioRate24 | output | 1 | Captured serial-I/O rate select; 1 means 24 MHz |
| strapValid | output | 1 | High once the captured values are usable |

## Verification
The capture assertion assumes that `padIn` is stable through the whole sampling cycle. The bench therefore changes pad levels only at falling clock edges. It also assumes the straps come from resistors and never from the block's own drivers. The bench pad model meets this by returning the strap level only while `padOe` is 0. `rstN` is treated as asynchronous, but the bench asserts and releases it on falling edges so that edge counts are unambiguous. Garbage strap levels are applied early in each wait and the real level only in the last cycle. This shows that only the final cycle counts.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef struct packed {
    logic sampleNow;
    logic timerRun;
  } ctlStrobes_t;
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int TERM_COUNT = 28636
) (
  input  logic        clk,
  input  logic        rstN,
  output ctlStrobes_t strobes
);
  localparam int CNT_W = $clog2(TERM_COUNT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM_COUNT - 1);

  logic [CNT_W-1:0] waitCnt;
  logic             waitDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt  <= '0;
      waitDone <= 1'b0;
    end else if (!waitDone) begin
      if (waitCnt == LAST) waitDone <= 1'b1;
      else                 waitCnt  <= waitCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.timerRun  = !waitDone;
    strobes.sampleNow = !waitDone && (waitCnt == LAST);
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= LAST); // R2
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    waitDone |=> waitDone); // R2
  AST_SAMPLE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sampleNow |=> !strobes.sampleNow); // R2
endmodule

// File: rtl/strap_dp.sv
module strap_dp
  import strap_pkg::*;
#(
  parameter int FS_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [FS_W:0]     padIn,
  input  logic [FS_W:0]     clkSrc,
  output logic [FS_W:0]     padOut,
  output logic [FS_W:0]     padOe,
  output logic [FS_W-1:0]   fsCode,
  output logic              sioRate24,
  output logic              strapValid
);
  localparam int NUM_PINS = FS_W + 1;
  localparam int SIO_IDX  = FS_W;

  logic [NUM_PINS-1:0] capReg;
  logic [NUM_PINS-1:0] oeReg;
  logic                validReg;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        capReg[i] <= 1'b0;
        oeReg[i]  <= 1'b0;
      end else if (strobes.sampleNow) begin
        capReg[i] <= padIn[i];
        oeReg[i]  <= 1'b1;
      end
    end
    assign padOut[i] = oeReg[i] & clkSrc[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  validReg <= 1'b0;
    else if (strobes.sampleNow) validReg <= 1'b1;
  end

  assign padOe      = oeReg;
  assign fsCode     = capReg[FS_W-1:0];
  assign sioRate24  = capReg[SIO_IDX];
  assign strapValid = validReg;

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validReg) |-> capReg == $past(padIn)); // R3
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    validReg |=> $stable(capReg)); // R6
  AST_OE_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (oeReg == '0 && !validReg) || (oeReg == '1 && validReg)); // R5
  AST_NO_EARLY_OE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.timerRun && !strobes.sampleNow |-> oeReg == '0); // R2
endmodule

// File: rtl/strap_capture_top.sv
module strap_capture_top
  import strap_pkg::*;
#(
  parameter int TERM_COUNT = 28636
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] padIn,
  input  logic [5:0] clkSrc,
  output logic [5:0] padOut,
  output logic [5:0] padOe,
  output logic [4:0] fsCode,
  output logic       sioRate24,
  output logic       strapValid
);
  ctlStrobes_t strobes;

  strap_ctrl #(.TERM_COUNT(TERM_COUNT)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes)
  );

  strap_dp #(.FS_W(5)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .padIn      (padIn),
    .clkSrc     (clkSrc),
    .padOut     (padOut),
    .padOe      (padOe),
    .fsCode     (fsCode),
    .sioRate24  (sioRate24),
    .strapValid (strapValid)
  );
endmodule

// File: tb/tb_strap_capture_top.sv
module tb_strap_capture_top;
  localparam int TC = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] strapLvl = '0;
  logic [5:0] padIn;
  logic [5:0] clkSrc = '0;
  logic [5:0] padOut, padOe;
  logic [4:0] fsCode;
  logic       sioRate24, strapValid;

  int checks = 0;
  int errors = 0;
  logic [5:0] expQ[$];
  logic       prevValid = 1'b0;
  logic       finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) clkSrc <= ~clkSrc ^ 6'b010101;

  // pad model: strap resistor level when floating, driver value otherwise
  for (genvar i = 0; i < 6; i++) begin : g_pad
    assign padIn[i] = padOe[i] ? padOut[i] : strapLvl[i];
  end

  strap_capture_top #(.TERM_COUNT(TC)) dut (
    .clk(clk), .rstN(rstN), .padIn(padIn), .clkSrc(clkSrc),
    .padOut(padOut), .padOe(padOe), .fsCode(fsCode),
    .sioRate24(sioRate24), .strapValid(strapValid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected captures when the valid flag rises
  always @(negedge clk) begin
    if (rstN && strapValid && !prevValid) begin
      if (expQ.size() == 0) chk(1'b0, "R3 unexpected capture", 1, 0);
      else begin
        logic [5:0] e;
        e = expQ.pop_front();
        chk(fsCode == e[4:0], "R3 fsCode", fsCode, e[4:0]);
        chk(sioRate24 == e[5], "R4 sioRate24", sioRate24, e[5]);
        chk(padOe == 6'h3f, "R5 oe with valid", padOe, 6'h3f);
      end
    end
    prevValid = rstN ? strapValid : 1'b0;
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(padOe == 0 && !strapValid, "R1/R8 reset clears", {padOe, strapValid}, 0);
    chk(fsCode == 0 && !sioRate24, "R1 reset values", {fsCode, sioRate24}, 0);
    rstN = 1'b1;
  endtask

  // full wait: garbage early, real strap in the last cycle
  task automatic runSeq(input logic [5:0] strap, input logic [5:0] junk);
    doReset();
    strapLvl = junk;
    for (int k = 0; k < TC - 1; k++) begin
      @(negedge clk);
      if (padOe != 0 || padOut != 0) begin
        chk(1'b0, "R2/R7 early drive", {padOe, padOut}, 0);
      end
    end
    chk(padOe == 0 && !strapValid, "R2 still floating", padOe, 0);
    strapLvl = strap;
    expQ.push_back(strap);
    @(negedge clk);
    chk(padOe == 6'h3f && strapValid, "R2 turnaround edge", padOe, 6'h3f);
    chk(fsCode == strap[4:0], "R9 last-cycle level", fsCode, strap[4:0]);
    for (int k = 0; k < 4; k++) begin
      strapLvl = ~strapLvl;
      @(negedge clk);
      chk(padOut == clkSrc, "R7 follows clkSrc", padOut, clkSrc);
      chk(fsCode == strap[4:0] && sioRate24 == strap[5], "R6 frozen",
          {sioRate24, fsCode}, strap);
      chk(padOe == 6'h3f, "R2 stays enabled", padOe, 6'h3f);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk(padOe == 0 && !strapValid && fsCode == 0, "R1 in reset", padOe, 0);
    runSeq(6'b101101, 6'b010010);
    runSeq(6'b010011, 6'b101100);
    runSeq(6'b000000, 6'b111111);
    runSeq(6'b111111, 6'b000000);
    // R8: reset midway through the wait, then full wait again
    doReset();
    repeat (TC / 2) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(padOe == 0 && !strapValid, "R8 mid reset", padOe, 0);
    rstN = 1'b1;
    repeat (TC - 1) @(negedge clk);
    chk(padOe == 0, "R8 timer restarted", padOe, 0);
    strapLvl = 6'b100001;
    expQ.push_back(6'b100001);
    @(negedge clk);
    chk(padOe == 6'h3f, "R8 enable after full wait", padOe, 6'h3f);
    // R8: reset after turnaround
    doReset();
    chk(padOe == 0, "R8 reset after turnaround", padOe, 0);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R3 all captures seen", expQ.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule